// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Interrupt Output

This block watches the calendar time of a real-time clock and raises an active-low interrupt when the time reaches a programmed alarm. Six alarm bytes hold the target values for seconds, minutes, hours, date, month and day of week. There is no alarm byte for the year. Each alarm byte has the same layout as the matching time byte, except that bit 7 arms that field. The alarm fires when every armed field equals the current time. The comparison runs only on the once-per-second advance strobe, so a given second can give at most one alarm event.

Software reaches the block through a simple register port: a write strobe, a read strobe, an address and one data byte each way. The port covers the six alarm bytes, a status byte and a control byte. In the latched mode, an alarm sets a sticky flag and holds the interrupt low until software clears the flag. In the pulsed mode, the interrupt gives a fixed-length low pulse on every alarm and keeps doing so without being reprogrammed. An optional auto-clear setting clears the flag when the status byte is read. While the control byte selects the frequency-output function, the alarm leaves the interrupt pin alone.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, every register (addresses 0 to 7) reads 8'h00 and irq_n is 1.
- R2: Addresses 0 to 5 are the alarm bytes for seconds, minutes, hours, date, month and day of week, in that order. A write stores the full byte and a read returns it on reg_rdata in the same cycle. Control byte (address 7) keeps bit 0 = pulsed mode and bit 1 = frequency-output select; its other bits read as 0.
- R3: When sec_tick is 1, at least one alarm byte has bit 7 set, and every armed byte's bits 6:0 equal bits 6:0 of the matching time input, the alarm flag (status address 6, bit 0) is 1 from the next clock edge on. If any armed field differs, nothing happens.
- R4: If no alarm byte has bit 7 set, no alarm event ever occurs, whatever the time inputs are.
- R5: Without sec_tick, a matching time produces no alarm event.
- R6: In latched mode (control bit 0 = 0, bit 1 = 0), irq_n is 0 exactly while the alarm flag is 1.
- R7: In pulsed mode (control bit 0 = 1, bit 1 = 0), each alarm event drives irq_n low for exactly PULSE_LEN cycles, starting the cycle after the event. Every later event pulses again.
- R8: Writing status with bit 0 = 0 clears the alarm flag. Writing bit 0 = 1 never sets it. The write stores status bit 7 (auto-clear enable).
- R9: When status bit 7 is 1, a status read returns the current flag and then clears it. When bit 7 is 0, a read leaves the flag unchanged.
- R10: While control bit 1 = 1, irq_n stays 1 even when the alarm flag is set.
- R11: An alarm event in the same cycle as a clearing write or an auto-clearing read leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read can trigger auto-clear) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours, BCD |
| tm_date | input | 8 | Current date, BCD |
| tm_month | input | 8 | Current month, BCD |
| tm_dow | input | 8 | Current day of week |
| sec_tick | input | 1 | One-cycle strobe on each second advance |
| irq_n | output | 1 | Active-low interrupt |

## Verification
On every cycle, the assertions check these rules:
- only a compare hit can raise the alarm flag, and a hit always leaves the flag set;
- a clearing write or an auto-clearing read empties the flag unless a hit arrives in the same cycle;
- the pulse counter reloads on each hit and then counts down one per cycle;
- with no armed field, or without the strobe, no hit occurs;
- the pin follows the flag in latched mode and stays high under frequency-output select.

Some behaviour only the bench scenarios can show. These are the exact pulse length seen at the pin, repeated pulses on later seconds, and readback of every register. They also cover multi-field matches that fail on one field, and the difference between reads with auto-clear on and off.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 4;

  localparam int ADDR_STATUS = 6;
  localparam int ADDR_CTRL   = 7;

  localparam int ARM_BIT       = 7;
  localparam int STAT_AUTO_BIT = 7;
  localparam int STAT_FLAG_BIT = 0;
  localparam int CTRL_PULSE_BIT = 0;
  localparam int CTRL_FSEL_BIT  = 1;

  // A field agrees when it is not armed, or when its value bits equal the time.
  function automatic logic field_agrees(input logic [DATA_W-1:0] alarm_b,
                                        input logic [DATA_W-1:0] time_b);
    return !alarm_b[ARM_BIT] || (alarm_b[ARM_BIT-1:0] == time_b[ARM_BIT-1:0]);
  endfunction

  function automatic logic field_armed(input logic [DATA_W-1:0] alarm_b);
    return alarm_b[ARM_BIT];
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  output logic [NF-1:0][DW-1:0] alarm_bytes,
  output logic                  pulse_mode,
  output logic                  fout_sel
);
  for (genvar g = 0; g < NF; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          alarm_bytes[g] <= '0;
      else if (wr && addr == AW'(g))       alarm_bytes[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_mode <= 1'b0;
      fout_sel   <= 1'b0;
    end else if (wr && addr == AW'(ADDR_CTRL)) begin
      pulse_mode <= wdata[CTRL_PULSE_BIT];
      fout_sel   <= wdata[CTRL_FSEL_BIT];
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int DW = DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NF-1:0][DW-1:0] alarm_bytes,
  input  logic [NF-1:0][DW-1:0] time_bytes,
  input  logic                  tick,
  output logic                  any_armed,
  output logic                  hit
);
  logic [NF-1:0] agree;
  logic [NF-1:0] armed;

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign agree[g] = field_agrees(alarm_bytes[g], time_bytes[g]);
    assign armed[g] = field_armed(alarm_bytes[g]);
  end

  assign any_armed = |armed;
  assign hit       = tick && any_armed && (&agree);

  // R4: nothing armed means no event
  a_r4_unarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !any_armed |-> !hit);
  // R5: events only on the second strobe
  a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !hit);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag
  import rtc_alarm_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          st_wr,
  input  logic          st_rd,
  input  logic [DW-1:0] wdata,
  output logic          flag,
  output logic          auto_clr
);
  logic sw_clear;
  logic rd_clear;

  assign sw_clear = st_wr && !wdata[STAT_FLAG_BIT];
  assign rd_clear = st_rd && auto_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      auto_clr <= 1'b0;
    end else begin
      if (st_wr) auto_clr <= wdata[STAT_AUTO_BIT];
      if (hit)                       flag <= 1'b1;
      else if (sw_clear || rd_clear) flag <= 1'b0;
    end
  end

  // R3 / R11: a hit always leaves the flag set
  a_r3_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  // R8: software never raises the flag
  a_r8_only_hw_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));
  // R8: clearing write empties the flag
  a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !wdata[STAT_FLAG_BIT] && !hit) |=> !flag);
  // R9: auto-clear read empties the flag
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && auto_clr && !hit) |=> !flag);
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic flag,
  input  logic pulse_mode,
  input  logic fout_sel,
  output logic irq_n,
  output logic pulse_active
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (hit)            remain <= CW'(PULSE_LEN);
    else if (remain != '0)   remain <= remain - CW'(1);
  end

  assign pulse_active = (remain != '0);

  always_comb begin
    if (fout_sel)        irq_n = 1'b1;
    else if (pulse_mode) irq_n = !pulse_active;
    else                 irq_n = !flag;
  end

  // R7: each hit reloads the full pulse length
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> remain == CW'(PULSE_LEN));
  // R7: the pulse counts down one per cycle
  a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (remain != '0 && !hit) |=> remain == $past(remain) - CW'(1));
  // R7: never beyond the pulse length
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CW'(PULSE_LEN));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [DATA_W-1:0]   tm_sec,
  input  logic [DATA_W-1:0]   tm_min,
  input  logic [DATA_W-1:0]   tm_hour,
  input  logic [DATA_W-1:0]   tm_date,
  input  logic [DATA_W-1:0]   tm_month,
  input  logic [DATA_W-1:0]   tm_dow,
  input  logic                sec_tick,
  output logic                irq_n
);
  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_bytes;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] time_bytes;
  logic pulse_mode, fout_sel, any_armed, hit, flag, auto_clr, pulse_active;
  logic st_wr, st_rd;

  assign time_bytes = {tm_dow, tm_month, tm_date, tm_hour, tm_min, tm_sec};
  assign st_wr = reg_wr && reg_addr == ADDR_W'(ADDR_STATUS);
  assign st_rd = reg_rd && reg_addr == ADDR_W'(ADDR_STATUS);

  alarm_regfile #(.NF(NUM_FIELDS), .DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .alarm_bytes(alarm_bytes), .pulse_mode(pulse_mode), .fout_sel(fout_sel));

  alarm_match #(.NF(NUM_FIELDS), .DW(DATA_W)) u_match (
    .clk(clk), .rst_n(rst_n), .alarm_bytes(alarm_bytes), .time_bytes(time_bytes),
    .tick(sec_tick), .any_armed(any_armed), .hit(hit));

  alarm_flag #(.DW(DATA_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .st_wr(st_wr), .st_rd(st_rd),
    .wdata(reg_wdata), .flag(flag), .auto_clr(auto_clr));

  alarm_irq #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk(clk), .rst_n(rst_n), .hit(hit), .flag(flag), .pulse_mode(pulse_mode),
    .fout_sel(fout_sel), .irq_n(irq_n), .pulse_active(pulse_active));

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = alarm_bytes[i];
    if (reg_addr == ADDR_W'(ADDR_STATUS)) begin
      reg_rdata[STAT_AUTO_BIT] = auto_clr;
      reg_rdata[STAT_FLAG_BIT] = flag;
    end
    if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
      reg_rdata[CTRL_PULSE_BIT] = pulse_mode;
      reg_rdata[CTRL_FSEL_BIT]  = fout_sel;
    end
  end

  // R6: latched mode pin mirrors the flag
  a_r6_latched_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && !fout_sel) |-> (irq_n == !flag));
  // R10: frequency-output select keeps the alarm off the pin
  a_r10_fsel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fout_sel |-> irq_n);
  // R7: pulsed mode pin follows the pulse window
  a_r7_pulse_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && !fout_sel) |-> (irq_n == !pulse_active));
endmodule

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, tick = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] tm [6];
  logic irq_n;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  int m_al [6];
  int m_flag, m_auto, m_mode, m_fsel, m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_irq #(.PULSE_LEN(PLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .tm_sec(tm[0]), .tm_min(tm[1]),
    .tm_hour(tm[2]), .tm_date(tm[3]), .tm_month(tm[4]), .tm_dow(tm[5]),
    .sec_tick(tick), .irq_n(irq_n));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_hit();
    int armed = 0;
    if (!tick) return 0;
    for (int i = 0; i < 6; i++) begin
      if (m_al[i] >= 128) begin
        armed++;
        if ((m_al[i] % 128) != (tm[i] % 128)) return 0;
      end
    end
    return (armed > 0) ? 1 : 0;
  endfunction

  function automatic int model_irq();
    if (m_fsel) return 1;
    if (m_mode) return (m_cnt == 0) ? 1 : 0;
    return m_flag ? 0 : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m_al[i] = 0;
      m_flag = 0; m_auto = 0; m_mode = 0; m_fsel = 0; m_cnt = 0;
    end else begin
      int h, old_auto;
      h = model_hit();
      old_auto = m_auto;
      if (wr && addr < 6) m_al[addr] = wdata;
      if (wr && addr == 7) begin m_mode = wdata[0]; m_fsel = wdata[1]; end
      if (wr && addr == 6) begin
        m_auto = wdata[7];
        if (wdata[0] == 0) m_flag = 0;
      end
      if (rd && addr == 6 && old_auto) m_flag = 0;
      if (h) m_flag = 1;
      if (h) m_cnt = PLEN; else if (m_cnt > 0) m_cnt--;
    end
  end

  // per-cycle comparison of the pin with the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tag;
      tag = m_fsel ? "R10 pin" : (m_mode ? "R7 pin" : "R6 pin");
      check(irq_n == model_irq(), tag, irq_n, model_irq());
    end
  end

  task automatic write_reg(input int a, input int d);
    addr = 4'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic read_reg(input int a, input int exp, input string tag);
    addr = 4'(a); rd = 1'b1;
    #1;
    check(rdata == 8'(exp), tag, rdata, exp);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic set_time(input int s, input int m, input int h,
                          input int d, input int mo, input int w);
    tm[0] = 8'(s); tm[1] = 8'(m); tm[2] = 8'(h);
    tm[3] = 8'(d); tm[4] = 8'(mo); tm[5] = 8'(w);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all_alarms();
    for (int i = 0; i < 6; i++) write_reg(i, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    set_time(0, 0, 0, 1, 1, 0);
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    for (int a = 0; a < 8; a++) read_reg(a, 0, "R1 reset read");
    check(irq_n == 1'b1, "R1 reset irq_n", irq_n, 1);

    // R2: register readback
    for (int a = 0; a < 6; a++) write_reg(a, 8'h11 * (a + 1));
    for (int a = 0; a < 6; a++) read_reg(a, 8'h11 * (a + 1), "R2 alarm readback");
    write_reg(7, 8'hFD);
    read_reg(7, 8'h01, "R2 control readback");
    write_reg(7, 8'h00);
    clear_all_alarms();

    // R3, R6: seconds-only latched alarm
    write_reg(0, 8'hB0);
    set_time(8'h29, 8'h12, 8'h08, 8'h15, 8'h06, 3);
    pulse_tick();
    read_reg(6, 8'h00, "R3 mismatch no flag");
    set_time(8'h30, 8'h12, 8'h08, 8'h15, 8'h06, 3);
    idle(2);
    read_reg(6, 8'h00, "R5 match without tick");
    pulse_tick();
    read_reg(6, 8'h01, "R3 match sets flag");
    check(irq_n == 1'b0, "R6 latched low", irq_n, 0);
    idle(5);
    check(irq_n == 1'b0, "R6 stays low", irq_n, 0);

    // R8: write 1 keeps, write 0 clears, write 1 never sets
    write_reg(6, 8'h01);
    read_reg(6, 8'h01, "R8 write one keeps");
    write_reg(6, 8'h00);
    read_reg(6, 8'h00, "R8 write zero clears");
    check(irq_n == 1'b1, "R6 released", irq_n, 1);
    write_reg(6, 8'h01);
    read_reg(6, 8'h00, "R8 write one ignored");

    // R3: multi-field, one field wrong
    write_reg(1, 8'h80 | 8'h45);
    write_reg(2, 8'h80 | 8'h17);
    set_time(8'h30, 8'h44, 8'h17, 8'h15, 8'h06, 3);
    pulse_tick();
    read_reg(6, 8'h00, "R3 multi mismatch");
    set_time(8'h30, 8'h45, 8'h17, 8'h15, 8'h06, 3);
    pulse_tick();
    read_reg(6, 8'h01, "R3 multi match");
    write_reg(6, 8'h00);

    // R4: nothing armed, values equal
    write_reg(0, 8'h30); write_reg(1, 8'h45); write_reg(2, 8'h17);
    pulse_tick();
    idle(1);
    read_reg(6, 8'h00, "R4 unarmed no alarm");

    // R9: auto-clear on status read
    write_reg(5, 8'h83);
    write_reg(6, 8'h80);
    pulse_tick();
    read_reg(6, 8'h81, "R9 read returns flag");
    read_reg(6, 8'h80, "R9 flag cleared by read");
    write_reg(6, 8'h00);
    pulse_tick();
    read_reg(6, 8'h01, "R9 no auto first read");
    read_reg(6, 8'h01, "R9 no auto flag kept");

    // R11: hit wins over same-cycle clearing write
    addr = 4'd6; wdata = 8'h00; wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
    read_reg(6, 8'h01, "R11 hit beats clear");
    write_reg(6, 8'h00);

    // R10: frequency-output select silences the pin
    write_reg(7, 8'h02);
    pulse_tick();
    check(irq_n == 1'b1, "R10 fsel high", irq_n, 1);
    read_reg(6, 8'h01, "R10 flag still set");
    write_reg(6, 8'h00);

    // R7: pulsed mode, exact length, repeats
    write_reg(7, 8'h01);
    for (int k = 0; k < 2; k++) begin
      int lows;
      lows = 0;
      pulse_tick();
      for (int c = 0; c < PLEN + 3; c++) begin
        if (irq_n == 1'b0) lows++;
        @(negedge clk);
      end
      check(lows == PLEN, "R7 pulse length", lows, PLEN);
    end
    write_reg(6, 8'h00);
    write_reg(7, 8'h00);
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule